// File: doc/BRIEF.md
# Parallel Bus Transmit Engine

This block sends a frame of bits across a parallel output bus of 1, 2, 4, 8 or 16 lines. It takes the payload from a byte stream that uses a valid/ready handshake. The frame length is given in bits, not bytes. An output bit clock is derived from the system clock by a divider whose ratio is fixed at build time. Between frames the bus carries a programmable idle word. Optionally the top line carries a frame-valid strobe, and the bit clock can be gated by that strobe or by the top data line. At frame end a sticky end-of-frame flag is raised.

Software writes the configuration inputs, then pulses `start`. The engine checks the configuration. It ignores a start that carries an illegal setting and ignores a start that arrives while a frame is running.

A four-state machine sequences each frame:
- **IDLE**: drives the idle word. It leaves on an accepted start and latches the configuration.
- **FLUSH**: empties the unpacking stage and resets the clock phase, so no bits from an earlier frame are sent. It always moves on to PRIME.
- **PRIME**: fetches bytes until the first beat is complete. It then loads that beat and enters RUN.
- **RUN**: sends one beat per bit-clock period. It returns to IDLE when the period of the last beat has elapsed.

Top module: `ptx_engine`

## Requirements
- R1: `cfg_wlog` selects the bus width as 2^`cfg_wlog` lines (0→1, 1→2, 2→4, 3→8, 4→16). A start with `cfg_wlog` above 4 is ignored: `busy_o` stays low and no byte is fetched.
- R2: With `cfg_valid_en` set, line 15 of `dat_o` is high during every beat of the frame. A start with `cfg_valid_en` set and width 16 is ignored.
- R3: While no frame runs, including after a frame ends, `dat_o` carries `cfg_idle` masked to the configured width. When `cfg_valid_en` is set, bit 15 is also cleared.
- R4: A frame sends exactly `cfg_len`/W beats, where W is the width. A start is ignored when `cfg_len` is zero or is not a multiple of W.
- R5: Least-significant-first packing applies when `cfg_msb_first` is 0:
  - for W below 8, beat k is bits [(k·W mod 8) +: W] of byte ⌊k·W/8⌋;
  - for W = 8, beat k is byte k;
  - for W = 16, beat k is byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
  In every case, lines above the width are 0.
- R6: For W below 8 with `cfg_msb_first` = 1, beat k is bits [(8−W−(k·W mod 8)) +: W] of byte ⌊k·W/8⌋. For W of 8 or 16 the setting has no effect.
- R7: The divider is DIV = ⌈SRC_HZ/OUT_HZ⌉ (4 by default). Each beat lasts DIV clock cycles. With `cfg_fall_edge` = 0, `bclk_o` is high for the first DIV/2 cycles of a beat and low for the rest, so data changes on its rising edge.
- R8: With `cfg_fall_edge` = 1 the bit clock is inverted: low for the first DIV/2 cycles of a beat, so data changes on its falling edge.
- R9: With `cfg_gate_en` set, `bclk_o` is held low during any beat whose gate line is low. The gate line is the valid strobe when `cfg_valid_en` is set, otherwise `dat_o[15]`. A start with gating on, valid off and width below 16 is ignored.
- R10: An accepted start first flushes the unpacking stage. The engine then fetches exactly ⌈`cfg_len`/8⌉ bytes and discards unused bits of the last byte. A start pulse during a frame is ignored.
- R11: At frame end `busy_o` falls, `bclk_o` is parked low and the end-of-frame flag is set. The flag stays set until `eof_clr` is pulsed. `irq_o` is the flag ANDed with `eof_en`.
- R12: `valid_o` is high exactly during the beats of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (source) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wlog | input | 3 | Log2 of bus width |
| cfg_len | input | LEN_W | Frame length in bits |
| cfg_idle | input | MAX_W | Idle word between frames |
| cfg_valid_en | input | 1 | Top line carries frame-valid strobe |
| cfg_msb_first | input | 1 | Unpack bytes from the top bit (width < 8) |
| cfg_gate_en | input | 1 | Gate bit clock by gate line |
| cfg_fall_edge | input | 1 | Data changes on bit-clock falling edge |
| start | input | 1 | Start strobe |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Engine accepts a byte |
| dat_o | output | MAX_W | Parallel bus |
| valid_o | output | 1 | Frame-valid strobe |
| bclk_o | output | 1 | Bit clock (gated, parked low) |
| busy_o | output | 1 | Frame in progress |
| eof_en | input | 1 | Interrupt enable |
| eof_clr | input | 1 | Clears the end-of-frame flag |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
The bench targets the following corner cases:
- **Packing order.** Frames of every width use irregular byte patterns, so a reversed packing order or wrong byte lane shows up as swapped nibbles or pairs.
- **Bit counts that are not whole bytes.** A 1-line, 12-bit frame and back-to-back frames show whether the engine drops the leftover bits. A design that over-fetches or skips the flush would emit stale bits into the next frame.
- **Illegal configurations.** A design that accepted them would raise `busy_o` or pull bytes.
- **Clock level.** The bit clock is checked at the launch and mid-point of every beat, across edge selection and gating. A mis-phased divider or an ungated clock shows up as a wrong level.
- **End-of-frame flag.** The flag is checked with the interrupt enable off and then on, to expose a flag that is not sticky.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int WLOG_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_PRIME,
        ST_RUN
    } ptx_state_e;

    function automatic int ceil_div(input longint num, input longint den);
        return int'((num + den - 1) / den);
    endfunction

endpackage

// File: rtl/ptx_clkdiv.sv
module ptx_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic adv,
    output logic last,
    output logic first_half
);
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (run) begin
            if (phase != PW'(DIV - 1)) begin
                phase <= phase + 1'b1;
            end else if (adv) begin
                phase <= '0;
            end
        end
    end

    assign last       = (phase == PW'(DIV - 1));
    assign first_half = (phase < PW'(HALF));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last && !adv && !clr) |=> last);

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last && adv && !clr) |=> first_half);

endmodule

// File: rtl/ptx_stage.sv
module ptx_stage #(
    parameter int MAX_W = 16,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CW-1:0]    w_cnt,
    input  logic             msb_first,
    input  logic [7:0]       byte_in,
    input  logic             push,
    input  logic             pop,
    output logic             have,
    output logic             want,
    output logic [MAX_W-1:0] beat
);
    logic [MAX_W-1:0] stg;
    logic [MAX_W-1:0] wmask;
    logic [MAX_W-1:0] byte_ext;
    logic [CW-1:0]    bits;
    logic             msb_mode;

    always_comb begin
        for (int i = 0; i < MAX_W; i++) begin
            wmask[i] = (CW'(i) < w_cnt);
        end
    end

    assign byte_ext = MAX_W'(byte_in);
    assign msb_mode = msb_first && (w_cnt < CW'(8));
    assign beat     = msb_mode ? (MAX_W'(stg[7:0] >> (CW'(8) - w_cnt)) & wmask)
                               : (stg & wmask);
    assign have     = (bits >= w_cnt);
    assign want     = (bits < w_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stg  <= '0;
            bits <= '0;
        end else if (push) begin
            stg  <= (bits == '0) ? byte_ext : (stg | (byte_ext << bits));
            bits <= bits + CW'(8);
        end else if (pop) begin
            stg  <= msb_mode ? (stg << w_cnt) : (stg >> w_cnt);
            bits <= bits - w_cnt;
        end
    end

    // R10
    pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> have);

    // R10
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    // R10
    bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits <= CW'(MAX_W));

endmodule

// File: rtl/ptx_engine.sv
module ptx_engine
    import ptx_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int LEN_W  = 16,
    parameter int SRC_HZ = 100_000_000,
    parameter int OUT_HZ = 30_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WLOG_W-1:0] cfg_wlog,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [MAX_W-1:0]  cfg_idle,
    input  logic              cfg_valid_en,
    input  logic              cfg_msb_first,
    input  logic              cfg_gate_en,
    input  logic              cfg_fall_edge,
    input  logic              start,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [MAX_W-1:0]  dat_o,
    output logic              valid_o,
    output logic              bclk_o,
    output logic              busy_o,
    input  logic              eof_en,
    input  logic              eof_clr,
    output logic              irq_o
);
    localparam int DIV      = ceil_div(SRC_HZ, OUT_HZ);
    localparam int CW       = $clog2(MAX_W) + 1;
    localparam int WLOG_MAX = $clog2(MAX_W);
    localparam int VLINE    = MAX_W - 1;
    localparam logic [MAX_W-1:0] VBIT = {1'b1, {(MAX_W-1){1'b0}}};

    ptx_state_e state_q, state_d;

    logic [WLOG_W-1:0] lat_wlog;
    logic [LEN_W-1:0]  lat_len, fetch_rem, bits_rem;
    logic              lat_valid_en, lat_msb, lat_gate, lat_fall;
    logic [MAX_W-1:0]  bus_q, idle_word, live_mask, beat;
    logic              vld_q, eof_flag;
    logic [CW-1:0]     w_live, w_lat;
    logic              cfg_bad, accept, have, want, push, beat_go, finish;
    logic              ph_last, ph_first, gate_line;

    assign w_live = CW'(1) << cfg_wlog;
    assign w_lat  = CW'(1) << lat_wlog;

    always_comb begin
        for (int i = 0; i < MAX_W; i++) begin
            live_mask[i] = (CW'(i) < w_live);
        end
    end

    assign idle_word = cfg_idle & live_mask & ~(cfg_valid_en ? VBIT : '0);

    assign cfg_bad = (cfg_wlog > WLOG_W'(WLOG_MAX))
                  || (cfg_len == '0)
                  || ((cfg_len & LEN_W'(w_live - 1'b1)) != '0)
                  || (cfg_valid_en && (w_live > CW'(VLINE)))
                  || (cfg_gate_en && !cfg_valid_en && (w_live <= CW'(VLINE)));

    assign accept  = (state_q == ST_IDLE) && start && !cfg_bad;
    assign beat_go = have && ((state_q == ST_PRIME)
                  || ((state_q == ST_RUN) && ph_last && (bits_rem != '0)));
    assign finish  = (state_q == ST_RUN) && ph_last && (bits_rem == '0);
    assign in_ready = ((state_q == ST_PRIME) || (state_q == ST_RUN))
                   && want && (fetch_rem != '0) && !beat_go;
    assign push    = in_ready && in_valid;

    ptx_clkdiv #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state_q == ST_FLUSH),
        .run        (state_q == ST_RUN),
        .adv        (beat_go),
        .last       (ph_last),
        .first_half (ph_first)
    );

    ptx_stage #(.MAX_W(MAX_W), .CW(CW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_FLUSH),
        .w_cnt     (w_lat),
        .msb_first (lat_msb),
        .byte_in   (in_data),
        .push      (push),
        .pop       (beat_go),
        .have      (have),
        .want      (want),
        .beat      (beat)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_PRIME;
            ST_PRIME: if (have) state_d = ST_RUN;
            ST_RUN:   if (finish) state_d = ST_IDLE;
        endcase
    end

    // outputs and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q        <= '0;
            vld_q        <= 1'b0;
            eof_flag     <= 1'b0;
            lat_wlog     <= '0;
            lat_len      <= '0;
            lat_valid_en <= 1'b0;
            lat_msb      <= 1'b0;
            lat_gate     <= 1'b0;
            lat_fall     <= 1'b0;
            fetch_rem    <= '0;
            bits_rem     <= '0;
        end else begin
            if (accept) begin
                lat_wlog     <= cfg_wlog;
                lat_len      <= cfg_len;
                lat_valid_en <= cfg_valid_en;
                lat_msb      <= cfg_msb_first;
                lat_gate     <= cfg_gate_en;
                lat_fall     <= cfg_fall_edge;
                fetch_rem    <= cfg_len;
            end else if (push) begin
                fetch_rem <= (fetch_rem > LEN_W'(8)) ? fetch_rem - LEN_W'(8) : '0;
            end
            if (beat_go) begin
                bus_q    <= beat | (lat_valid_en ? VBIT : '0);
                vld_q    <= 1'b1;
                bits_rem <= ((state_q == ST_PRIME) ? lat_len : bits_rem) - LEN_W'(w_lat);
            end else if ((state_q == ST_IDLE) || finish) begin
                bus_q <= idle_word;
                vld_q <= 1'b0;
            end
            if (finish)       eof_flag <= 1'b1;
            else if (eof_clr) eof_flag <= 1'b0;
        end
    end

    assign gate_line = lat_valid_en ? vld_q : bus_q[VLINE];
    assign bclk_o    = (state_q == ST_RUN) && (!lat_gate || gate_line) && (ph_first ^ lat_fall);
    assign dat_o     = bus_q;
    assign valid_o   = vld_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign irq_o     = eof_flag && eof_en;

    // R11
    eof_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_flag && !eof_clr) |=> eof_flag);

    // R11
    eof_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> eof_flag);

    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start && cfg_bad) |=> !busy_o);

    // R2
    vline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lat_valid_en) |-> dat_o[VLINE]);

    // R12
    valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> !busy_o);

endmodule

// File: tb/sim_ptx_engine.sv
`timescale 1ns/1ps
module sim_ptx_engine;
    localparam int MAX_W  = 16;
    localparam int LEN_W  = 16;
    localparam int SRC_HZ = 100_000_000;
    localparam int OUT_HZ = 30_000_000;
    localparam int DIV    = (SRC_HZ + OUT_HZ - 1) / OUT_HZ;
    localparam int HALF   = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_wlog = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [MAX_W-1:0] cfg_idle = '0;
    logic cfg_valid_en = 0, cfg_msb_first = 0, cfg_gate_en = 0, cfg_fall_edge = 0;
    logic start = 0, in_valid = 0, eof_en = 0, eof_clr = 0;
    logic [7:0] in_data = '0;
    logic in_ready, valid_o, bclk_o, busy_o, irq_o;
    logic [MAX_W-1:0] dat_o;

    int n_tests = 0, n_fail = 0;
    logic [7:0]  bq[$];
    logic [7:0]  pay[$];
    logic [15:0] exp_d[$];
    logic        exp_l[$];
    logic        exp_h[$];
    logic        acc = 0;
    logic        cur_h = 0;
    int          cnt = 0;
    string       cur_tag = "";

    always #4 clk = ~clk;

    ptx_engine #(.MAX_W(MAX_W), .LEN_W(LEN_W), .SRC_HZ(SRC_HZ), .OUT_HZ(OUT_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wlog(cfg_wlog), .cfg_len(cfg_len),
        .cfg_idle(cfg_idle), .cfg_valid_en(cfg_valid_en), .cfg_msb_first(cfg_msb_first),
        .cfg_gate_en(cfg_gate_en), .cfg_fall_edge(cfg_fall_edge), .start(start),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .dat_o(dat_o),
        .valid_o(valid_o), .bclk_o(bclk_o), .busy_o(busy_o), .eof_en(eof_en),
        .eof_clr(eof_clr), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // byte feeder
    initial begin
        forever begin
            @(negedge clk);
            if (acc) void'(bq.pop_front());
            in_valid = (bq.size() > 0);
            in_data  = (bq.size() > 0) ? bq[0] : 8'h00;
            acc      = in_valid && in_ready;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid_o) begin
                if (cnt == 0) begin
                    if (exp_d.size() == 0) begin
                        chk(0, {cur_tag, " R4 extra beat"}, dat_o, 0);
                    end else begin
                        logic [15:0] d;
                        logic l;
                        d = exp_d.pop_front();
                        l = exp_l.pop_front();
                        cur_h = exp_h.pop_front();
                        chk(dat_o == d, {cur_tag, " R5 beat data"}, dat_o, d);
                        chk(bclk_o == l, {cur_tag, " R7 launch clk"}, bclk_o, l);
                    end
                end else if (cnt == HALF) begin
                    chk(bclk_o == cur_h, {cur_tag, " R8 mid clk"}, bclk_o, cur_h);
                end
                cnt = (cnt + 1 == DIV) ? 0 : cnt + 1;
            end else begin
                cnt = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    task automatic run_frame(input string tag, input int wlog, input int len,
                             input bit msb, input bit ven, input bit gate,
                             input bit fall, input bit restart);
        int w;
        w = 1 << wlog;
        cur_tag = tag;
        for (int k = 0; k < len / w; k++) begin
            int off;
            logic [15:0] d;
            logic gp;
            off = k * w;
            if (w == 16)     d = {pay[2*k+1], pay[2*k]};
            else if (w == 8) d = {8'h00, pay[k]};
            else begin
                int sh;
                sh = msb ? (8 - w - (off % 8)) : (off % 8);
                d = 16'((pay[off/8] >> sh) & ((1 << w) - 1));
            end
            if (ven) d[15] = 1'b1;
            gp = !gate || (ven ? 1'b1 : d[15]);
            exp_d.push_back(d);
            exp_l.push_back(gp ? !fall : 1'b0);
            exp_h.push_back(gp ? fall : 1'b0);
        end
        for (int b = 0; b < (len + 7) / 8; b++) bq.push_back(pay[b]);
        @(negedge clk);
        cfg_wlog = 3'(wlog); cfg_len = LEN_W'(len); cfg_msb_first = msb;
        cfg_valid_en = ven; cfg_gate_en = gate; cfg_fall_edge = fall;
        pulse_start();
        chk(busy_o == 1'b1, {tag, " R10 busy after start"}, busy_o, 1);
        if (restart) begin
            repeat (10) @(negedge clk);
            pulse_start();
        end
        wait_idle();
        repeat (3) @(negedge clk);
        chk(exp_d.size() == 0, {tag, " R4 beat count"}, exp_d.size(), 0);
        chk(bq.size() == 0 && !in_ready, {tag, " R10 bytes fetched"}, bq.size(), 0);
        chk(!busy_o && !bclk_o && !valid_o, {tag, " R11 end parked"},
            {busy_o, bclk_o, valid_o}, 0);
        chk(dat_o == (cfg_idle & 16'((1 << w) - 1) & ~(ven ? 16'h8000 : 16'h0)),
            {tag, " R3 idle after frame"}, dat_o, cfg_idle);
        exp_d.delete(); exp_l.delete(); exp_h.delete();
    endtask

    task automatic try_bad(input string tag, input int wlog, input int len,
                           input bit ven, input bit gate);
        bq.push_back(8'h5A);
        @(negedge clk);
        cfg_wlog = 3'(wlog); cfg_len = LEN_W'(len); cfg_valid_en = ven;
        cfg_gate_en = gate; cfg_msb_first = 0; cfg_fall_edge = 0;
        pulse_start();
        repeat (4) @(negedge clk);
        chk(!busy_o, {tag, " reject busy"}, busy_o, 0);
        chk(bq.size() == 1, {tag, " reject no fetch"}, bq.size(), 1);
        bq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(dat_o == 0 && !valid_o && !bclk_o && !busy_o && !irq_o && !in_ready,
            "R11 reset state", dat_o, 0);

        // R3 idle masking
        cfg_idle = 16'hFFFF; cfg_wlog = 3'd2; cfg_valid_en = 0;
        repeat (2) @(negedge clk);
        chk(dat_o == 16'h000F, "R3 idle w4", dat_o, 16'h000F);
        cfg_wlog = 3'd3; cfg_valid_en = 1;
        repeat (2) @(negedge clk);
        chk(dat_o == 16'h00FF, "R3 idle w8 valid", dat_o, 16'h00FF);
        cfg_wlog = 3'd4; cfg_valid_en = 1;
        repeat (2) @(negedge clk);
        chk(dat_o == 16'h7FFF, "R3 idle w16 valid", dat_o, 16'h7FFF);
        cfg_idle = 16'hA5C3; cfg_valid_en = 0;

        pay = '{8'h3C, 8'hA1, 8'h07, 8'hF2};
        run_frame("R5 w8 lsb", 3, 32, 0, 0, 0, 0, 0);
        chk(!irq_o, "R11 irq masked", irq_o, 0);
        eof_en = 1;
        @(negedge clk);
        chk(irq_o, "R11 sticky flag", irq_o, 1);
        repeat (5) @(negedge clk);
        chk(irq_o, "R11 flag held", irq_o, 1);
        eof_clr = 1; @(negedge clk); eof_clr = 0; @(negedge clk);
        chk(!irq_o, "R11 flag cleared", irq_o, 0);

        pay = '{8'h1E, 8'hB4, 8'h69};
        run_frame("R5 w4 lsb", 2, 24, 0, 0, 0, 0, 0);
        chk(irq_o, "R11 flag set", irq_o, 1);
        pay = '{8'h1E, 8'hB4};
        run_frame("R6 w4 msb", 2, 16, 1, 0, 0, 0, 0);
        pay = '{8'h1B, 8'hE4};
        run_frame("R6 w2 msb", 1, 16, 1, 0, 0, 0, 0);
        pay = '{8'h96, 8'hF3};
        run_frame("R10 w1 partial", 0, 12, 0, 0, 0, 0, 0);
        pay = '{8'h12, 8'h34, 8'hC6, 8'h0F, 8'hAB, 8'h80};
        run_frame("R5 w16", 4, 48, 0, 0, 0, 0, 0);
        pay = '{8'h81, 8'h42, 8'h3C};
        run_frame("R6 w8 msb ignored", 3, 24, 1, 0, 0, 0, 0);
        pay = '{8'h55, 8'h7E, 8'h01};
        run_frame("R2 R12 w8 valid", 3, 24, 0, 1, 0, 0, 1);
        chk(!busy_o, "R10 restart ignored", busy_o, 0);
        pay = '{8'hD2, 8'h4B};
        run_frame("R8 w4 fall", 2, 16, 0, 0, 0, 1, 0);
        pay = '{8'h00, 8'h80, 8'h11, 8'h22, 8'hFF, 8'hFF};
        run_frame("R9 w16 gate data", 4, 48, 0, 0, 1, 0, 0);
        pay = '{8'hC9};
        run_frame("R9 w2 gate valid", 1, 8, 0, 1, 1, 0, 0);

        try_bad("R1 wlog5", 5, 16, 0, 0);
        try_bad("R4 len6 w4", 2, 6, 0, 0);
        try_bad("R4 len0", 3, 0, 0, 0);
        try_bad("R2 valid w16", 4, 32, 1, 0);
        try_bad("R9 gate no line", 3, 16, 0, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule